// File: doc/BRIEF.md
# Memory-Mapped 64-Input Interrupt Controller

The block sits on an APB slave port and gathers 64 interrupt inputs. These inputs must be synchronous to the bus clock. A rising edge on an input sets a sticky flag bit for that input. The flag holds the request until software writes the bit back to zero, so a one-cycle pulse is never lost. A level input that stays high also requests on its own.

A table of 64 byte-wide slots decides which input feeds each of the 64 channels. Each channel has an enable bit, and the enabled requests form two read-only pending words. A global enable bit gates a single request line to the processor. A 6-bit output names the highest-numbered pending channel, so the handler can go straight to it without scanning the pending words.

Top module: `apb_irq_ctrl`

## Requirements
- R1: Every APB access completes in its first access cycle: pready is 1 and pslverr is 0.
- R2: After reset the control, enable and flag registers read 0. The slot of every channel c holds the value c, so each channel starts fed by the input with its own number.
- R3: A 0-to-1 change on input n sets flag bit n. Flags for inputs 31..0 are at offset 0x08 and flags for inputs 63..32 are at 0x20, with bit n%32 standing for input n. A set flag stays set until software writes that bit to 0.
- R4: A write to a flag word stores the written value. An input rising in the same cycle as the write still leaves its flag bit at 1.
- R5: Channel c is pending when its selected input is high or that input's flag is set, and enable bit c is 1. Pending bits for channels 31..0 read at 0x14, and for channels 63..32 at 0x2C, bit c%32.
- R6: The source table covers offsets 0x40 to 0x7C. In the word at 0x40+4m, byte lane k (bits 8k+7..8k) holds the input number for channel 4m+k in its low 6 bits. The top 2 bits of each lane read 0.
- R7: The control word is at 0x00 and stores only bit 31, the global enable; its other bits read 0. irq_req is 1 exactly when bit 31 is set and at least one channel is pending.
- R8: irq_id gives the highest-numbered pending channel, and 0 when no channel is pending.
- R9: Reads of any undefined or unaligned offset return 0. Writes to those offsets, or to the two pending words, leave every register unchanged.
- R10: The enable words at 0x10 (channels 31..0) and 0x28 (channels 63..32) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1; no wait states |
| pslverr | output | 1 | Always 0 |
| irq_src | input | 64 | Interrupt inputs, synchronous to pclk |
| irq_req | output | 1 | Request to the processor |
| irq_id | output | 6 | Highest pending channel number |

## Verification
The bench builds the block with its defaults: 64 inputs, a 12-bit address and 32-bit data. These put both halves of the flag, enable and pending words within reach, along with all sixteen table words. They also let a random remap send any channel to any input, including inputs from the opposite half. At this size the priority encoder can be driven across its full 0..63 range. A flag clear can be made to collide with a new rising edge on the same input in one cycle.

// File: rtl/apb_irq_pkg.sv
package apb_irq_pkg;
  localparam int NSRC        = 64;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 12;
  localparam int CH_W        = $clog2(NSRC);
  localparam int LANE_W      = 8;
  localparam int LANES       = DATA_W / LANE_W;
  localparam int TBL_WORDS   = NSRC / LANES;
  localparam int TBL_IDX_W   = $clog2(TBL_WORDS);
  localparam int TBL_SPAN_LSB = TBL_IDX_W + 2;

  localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_FLAG_LO = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_EN_LO   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_PEND_LO = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_FLAG_HI = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_EN_HI   = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_PEND_HI = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_TBL     = 12'h040;

  localparam int GEN_BIT = DATA_W - 1;
endpackage

// File: rtl/apb_irq_capture.sv
module apb_irq_capture
  import apb_irq_pkg::*;
#(
  parameter int N_IN = NSRC,
  parameter int DW   = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] src,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  output logic [N_IN-1:0] flag_q,
  output logic [N_IN-1:0] src_q
);
  logic [N_IN-1:0] rise;
  logic [N_IN-1:0] flag_n;

  assign rise = src & ~src_q;

  // software write first, edge capture last so a new edge wins
  always_comb begin
    flag_n = flag_q;
    if (wr_lo) flag_n[DW-1:0]    = wdata;
    if (wr_hi) flag_n[N_IN-1:DW] = wdata;
    flag_n = flag_n | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      src_q  <= '0;
    end else begin
      flag_q <= flag_n;
      src_q  <= src;
    end
  end
endmodule

// File: rtl/apb_irq_regs.sv
module apb_irq_regs
  import apb_irq_pkg::*;
#(
  parameter int N_IN = NSRC,
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int CW   = CH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [AW-1:0]      paddr,
  input  logic [DW-1:0]      pwdata,
  output logic [DW-1:0]      prdata,
  input  logic [N_IN-1:0]    flag_q,
  input  logic [N_IN-1:0]    pend,
  output logic               gen_en,
  output logic [N_IN-1:0]    en_q,
  output logic [N_IN*CW-1:0] slot_flat,
  output logic               flag_wr_lo,
  output logic               flag_wr_hi,
  output logic               tbl_wr
);
  localparam int NL = DW / LANE_W;

  logic          wr_acc;
  logic          rd_sel;
  logic          tbl_hit;
  logic [TBL_IDX_W-1:0] tbl_idx;

  logic          gen_q, gen_n;
  logic [N_IN-1:0] en_n;
  logic [CW-1:0] slot_q [N_IN];
  logic [CW-1:0] slot_n [N_IN];

  assign wr_acc  = psel & penable & pwrite;
  assign rd_sel  = psel & ~pwrite;
  assign tbl_hit = (paddr[AW-1:TBL_SPAN_LSB] == OFF_TBL[AW-1:TBL_SPAN_LSB])
                   && (paddr[1:0] == 2'b00);
  assign tbl_idx = paddr[2 +: TBL_IDX_W];

  assign flag_wr_lo = wr_acc && (paddr == OFF_FLAG_LO);
  assign flag_wr_hi = wr_acc && (paddr == OFF_FLAG_HI);
  assign tbl_wr     = wr_acc && tbl_hit;
  assign gen_en     = gen_q;

  // next-state
  always_comb begin
    gen_n  = gen_q;
    en_n   = en_q;
    slot_n = slot_q;
    if (wr_acc) begin
      if (paddr == OFF_CTRL)  gen_n = pwdata[GEN_BIT];
      if (paddr == OFF_EN_LO) en_n[DW-1:0]    = pwdata;
      if (paddr == OFF_EN_HI) en_n[N_IN-1:DW] = pwdata;
      if (tbl_hit) begin
        for (int k = 0; k < NL; k++) begin
          slot_n[int'(tbl_idx) * NL + k] = pwdata[LANE_W*k +: CW];
        end
      end
    end
  end

  // registers, with write access as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= 1'b0;
      en_q  <= '0;
      for (int c = 0; c < N_IN; c++) slot_q[c] <= CW'(c);
    end else if (wr_acc) begin
      gen_q  <= gen_n;
      en_q   <= en_n;
      slot_q <= slot_n;
    end
  end

  for (genvar c = 0; c < N_IN; c++) begin : g_flat
    assign slot_flat[c*CW +: CW] = slot_q[c];
  end

  // read mux
  always_comb begin
    prdata = '0;
    if (rd_sel) begin
      if (tbl_hit) begin
        for (int k = 0; k < NL; k++) begin
          prdata[LANE_W*k +: LANE_W] = LANE_W'(slot_q[int'(tbl_idx) * NL + k]);
        end
      end else begin
        case (paddr)
          OFF_CTRL:    prdata[GEN_BIT] = gen_q;
          OFF_FLAG_LO: prdata = flag_q[DW-1:0];
          OFF_FLAG_HI: prdata = flag_q[N_IN-1:DW];
          OFF_EN_LO:   prdata = en_q[DW-1:0];
          OFF_EN_HI:   prdata = en_q[N_IN-1:DW];
          OFF_PEND_LO: prdata = pend[DW-1:0];
          OFF_PEND_HI: prdata = pend[N_IN-1:DW];
          default:     prdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/apb_irq_route.sv
module apb_irq_route
  import apb_irq_pkg::*;
#(
  parameter int N_IN = NSRC,
  parameter int CW   = CH_W
) (
  input  logic [N_IN-1:0]    src,
  input  logic [N_IN-1:0]    flag_q,
  input  logic [N_IN-1:0]    en_q,
  input  logic [N_IN*CW-1:0] slot_flat,
  input  logic               gen_en,
  output logic [N_IN-1:0]    pend,
  output logic               irq_req,
  output logic [CW-1:0]      irq_id
);
  logic [N_IN-1:0] active;

  assign active = src | flag_q;

  for (genvar c = 0; c < N_IN; c++) begin : g_chan
    logic [CW-1:0] sel;
    assign sel     = slot_flat[c*CW +: CW];
    assign pend[c] = active[sel] & en_q[c];
  end

  // highest-numbered pending channel wins
  always_comb begin
    irq_id = '0;
    for (int c = 0; c < N_IN; c++) begin
      if (pend[c]) irq_id = CW'(c);
    end
  end

  assign irq_req = gen_en & (|pend);
endmodule

// File: rtl/apb_irq_ctrl.sv
module apb_irq_ctrl
  import apb_irq_pkg::*;
(
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NSRC-1:0]   irq_src,
  output logic              irq_req,
  output logic [CH_W-1:0]   irq_id
);
  logic [1:0]          rst_sync_q;
  logic                rst_n;
  logic [NSRC-1:0]     flag_q;
  logic [NSRC-1:0]     src_q;
  logic [NSRC-1:0]     pend;
  logic [NSRC-1:0]     en_q;
  logic [NSRC*CH_W-1:0] slot_flat;
  logic                gen_en;
  logic                flag_wr_lo;
  logic                flag_wr_hi;
  logic                tbl_wr;

  // asynchronous assert, synchronous release
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  apb_irq_regs u_regs (
    .clk(pclk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .flag_q(flag_q), .pend(pend),
    .gen_en(gen_en), .en_q(en_q), .slot_flat(slot_flat),
    .flag_wr_lo(flag_wr_lo), .flag_wr_hi(flag_wr_hi), .tbl_wr(tbl_wr)
  );

  apb_irq_capture u_cap (
    .clk(pclk), .rst_n(rst_n), .src(irq_src),
    .wr_lo(flag_wr_lo), .wr_hi(flag_wr_hi), .wdata(pwdata),
    .flag_q(flag_q), .src_q(src_q)
  );

  apb_irq_route u_route (
    .src(irq_src), .flag_q(flag_q), .en_q(en_q), .slot_flat(slot_flat),
    .gen_en(gen_en), .pend(pend), .irq_req(irq_req), .irq_id(irq_id)
  );
endmodule

// File: rtl/apb_irq_ctrl_chk.sv
module apb_irq_ctrl_chk
  import apb_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC-1:0]      irq_src,
  input logic [NSRC-1:0]      src_q,
  input logic [NSRC-1:0]      flag_q,
  input logic [NSRC-1:0]      pend,
  input logic                 gen_en,
  input logic                 irq_req,
  input logic [CH_W-1:0]      irq_id,
  input logic                 flag_wr_lo,
  input logic                 flag_wr_hi,
  input logic                 tbl_wr,
  input logic [NSRC*CH_W-1:0] slot_flat
);
  logic [NSRC-1:0] rise;
  assign rise = irq_src & ~src_q;

  a_r7_req_needs_gen: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gen_en);

  a_r7_req_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend) |-> !irq_req);

  a_r8_id_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend[irq_id]);

  a_r8_none_above: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend >> irq_id) == NSRC'(1)));

  a_r3_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((flag_q & $past(rise)) == $past(rise)));

  a_r3_flag_lo_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr_lo |=> ((~flag_q[DATA_W-1:0] & $past(flag_q[DATA_W-1:0])) == '0));

  a_r3_flag_hi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr_hi |=> ((~flag_q[NSRC-1:DATA_W] & $past(flag_q[NSRC-1:DATA_W])) == '0));

  a_r6_tbl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_wr |=> $stable(slot_flat));
endmodule

bind apb_irq_ctrl apb_irq_ctrl_chk chk_i (
  .clk(pclk), .rst_n(rst_n), .irq_src(irq_src), .src_q(src_q),
  .flag_q(flag_q), .pend(pend), .gen_en(gen_en), .irq_req(irq_req),
  .irq_id(irq_id), .flag_wr_lo(flag_wr_lo), .flag_wr_hi(flag_wr_hi),
  .tbl_wr(tbl_wr), .slot_flat(slot_flat)
);

// File: tb/apb_irq_ctrl_tb_top.sv
module apb_irq_ctrl_tb_top;
  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [63:0] irq_src;
  logic        irq_req;
  logic [5:0]  irq_id;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model
  bit        m_gen;
  bit [63:0] m_en, m_flag, m_prev;
  int        m_slot [64];

  always #10 pclk = ~pclk;

  apb_irq_ctrl dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq_src(irq_src),
    .irq_req(irq_req), .irq_id(irq_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [63:0] exp_pend();
    bit [63:0] p;
    for (int c = 0; c < 64; c++)
      p[c] = (irq_src[m_slot[c]] | m_flag[m_slot[c]]) & m_en[c];
    return p;
  endfunction

  function automatic bit [5:0] exp_id();
    bit [63:0] p = exp_pend();
    bit [5:0] id = 0;
    for (int c = 0; c < 64; c++) if (p[c]) id = 6'(c);
    return id;
  endfunction

  function automatic bit [31:0] exp_rd(input bit [11:0] a);
    bit [63:0] p = exp_pend();
    bit [31:0] v = 0;
    if (a >= 12'h040 && a <= 12'h07C && a[1:0] == 2'b00) begin
      for (int k = 0; k < 4; k++) v[8*k +: 8] = 8'(m_slot[(a - 12'h040) + k]);
      return v;
    end
    case (a)
      12'h000: v = {m_gen, 31'd0};
      12'h008: v = m_flag[31:0];
      12'h020: v = m_flag[63:32];
      12'h010: v = m_en[31:0];
      12'h028: v = m_en[63:32];
      12'h014: v = p[31:0];
      12'h02C: v = p[63:32];
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic model_wr(input bit [11:0] a, input bit [31:0] d);
    if (a >= 12'h040 && a <= 12'h07C && a[1:0] == 2'b00) begin
      for (int k = 0; k < 4; k++) m_slot[(a - 12'h040) + k] = int'(d[8*k +: 6]);
    end else begin
      case (a)
        12'h000: m_gen = d[31];
        12'h008: m_flag[31:0]  = d;
        12'h020: m_flag[63:32] = d;
        12'h010: m_en[31:0]    = d;
        12'h028: m_en[63:32]   = d;
        default: ;
      endcase
    end
  endtask

  task automatic apb_wr(input bit [11:0] a, input bit [31:0] d,
                        input bit with_src = 0, input bit [63:0] nsrc = 0);
    @(negedge pclk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge pclk);
    @(negedge pclk);
    penable = 1;
    if (with_src) irq_src = nsrc;
    #2;
    chk("R1 pready", {31'd0, pready}, 32'd1);
    chk("R1 pslverr", {31'd0, pslverr}, 32'd0);
    @(posedge pclk);
    model_wr(a, d);
    if (with_src) begin
      m_flag = m_flag | (nsrc & ~m_prev);
      m_prev = nsrc;
    end
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd_chk(input bit [11:0] a, input string req);
    bit [31:0] exp;
    @(negedge pclk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge pclk);
    @(negedge pclk);
    penable = 1;
    #2;
    exp = exp_rd(a);
    chk(req, prdata, exp);
    @(posedge pclk);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic chk_out(input string req);
    #2;
    chk({req, " irq_req"}, {31'd0, irq_req}, {31'd0, m_gen & (|exp_pend())});
    chk({req, " irq_id"}, {26'd0, irq_id}, {26'd0, exp_id()});
  endtask

  task automatic set_src(input bit [63:0] v);
    @(negedge pclk);
    irq_src = v;
    @(posedge pclk);
    m_flag = m_flag | (v & ~m_prev);
    m_prev = v;
    @(negedge pclk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge pclk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    bit [31:0] rs;
    bit [11:0] regs_list [11];
    regs_list = '{12'h000, 12'h008, 12'h010, 12'h014, 12'h020, 12'h028,
                  12'h02C, 12'h040, 12'h05C, 12'h07C, 12'h004};
    rs = $urandom(32'd4711);
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; irq_src = 0;
    m_gen = 0; m_en = 0; m_flag = 0; m_prev = 0;
    for (int c = 0; c < 64; c++) m_slot[c] = c;
    presetn = 0;
    repeat (3) @(posedge pclk);
    @(negedge pclk) presetn = 1;
    repeat (4) @(posedge pclk);

    // R2 reset state
    apb_rd_chk(12'h000, "R2 ctrl");
    apb_rd_chk(12'h010, "R2 en lo");
    apb_rd_chk(12'h028, "R2 en hi");
    apb_rd_chk(12'h008, "R2 flag lo");
    apb_rd_chk(12'h020, "R2 flag hi");
    chk("R2 table 0x40", exp_rd(12'h040), 32'h03020100);
    apb_rd_chk(12'h040, "R2 slot word 0x40");
    apb_rd_chk(12'h07C, "R2 slot word 0x7C");
    chk_out("R2");

    // R9 undefined / unaligned / read-only
    apb_rd_chk(12'h004, "R9 undef 0x04");
    apb_rd_chk(12'h080, "R9 undef 0x80");
    apb_rd_chk(12'h041, "R9 unaligned 0x41");
    apb_wr(12'h004, 32'hFFFF_FFFF);
    apb_wr(12'h014, 32'hFFFF_FFFF);
    apb_wr(12'h02C, 32'hFFFF_FFFF);
    apb_wr(12'h042, 32'hFFFF_FFFF);
    foreach (regs_list[i]) apb_rd_chk(regs_list[i], "R9 no side effect");

    // R7 only bit 31 stored, R10 enable readback
    apb_wr(12'h000, 32'hFFFF_FFFF);
    apb_rd_chk(12'h000, "R7 ctrl bit31 only");
    apb_wr(12'h010, 32'hA5A5_0F0F);
    apb_wr(12'h028, 32'h1234_5678);
    apb_rd_chk(12'h010, "R10 en lo");
    apb_rd_chk(12'h028, "R10 en hi");

    // R3 pulse capture and hold
    apb_wr(12'h010, 32'h0000_0020);
    apb_wr(12'h028, 32'h0);
    set_src(64'h20);
    set_src(64'h0);
    apb_rd_chk(12'h008, "R3 flag set by pulse");
    apb_rd_chk(12'h014, "R5 pend held by flag");
    chk("R3 pend bit5 model", exp_rd(12'h014), 32'h20);
    chk_out("R8 pulse");
    apb_wr(12'h008, 32'h0);
    apb_rd_chk(12'h014, "R3 cleared flag drops pend");
    chk_out("R7 after clear");

    // R4 edge beats same-cycle clear
    apb_wr(12'h008, 32'h0, 1, 64'h80);
    chk("R4 model flag7", m_flag[31:0], 32'h80);
    apb_rd_chk(12'h008, "R4 flag kept over clear");
    set_src(64'h0);
    apb_wr(12'h008, 32'h0);

    // R6 remap channel 40 to input 3; upper lane bits read 0
    apb_wr(12'h068, 32'h2B2A_2903);
    apb_wr(12'h028, 32'h0000_0100);
    apb_wr(12'h010, 32'h0);
    set_src(64'h8);
    apb_rd_chk(12'h068, "R6 slot readback");
    apb_rd_chk(12'h02C, "R6 remapped pend");
    chk_out("R8 remap");
    apb_wr(12'h05C, 32'hFFFF_FFFF);
    apb_rd_chk(12'h05C, "R6 upper lane bits zero");
    chk("R6 lane mask model", exp_rd(12'h05C), 32'h3F3F_3F3F);

    // R7 global enable gates
    apb_wr(12'h000, 32'h0);
    chk_out("R7 gen off");
    apb_wr(12'h000, 32'h8000_0000);
    chk_out("R7 gen on");
    apb_wr(12'h008, 32'h0);
    apb_wr(12'h020, 32'h0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 6);
      case (op)
        0, 1: set_src({$urandom(), $urandom()} & {$urandom(), $urandom()});
        2: apb_wr($urandom_range(0, 1) ? 12'h010 : 12'h028, $urandom());
        3: apb_wr(12'h040 + 12'($urandom_range(0, 15) * 4), $urandom());
        4: apb_wr($urandom_range(0, 1) ? 12'h008 : 12'h020, $urandom() & $urandom());
        5: apb_wr(12'h000, {$urandom_range(0, 3) != 0, 31'd0});
        default: apb_rd_chk(regs_list[$urandom_range(0, 10)], "R5 random read");
      endcase
      apb_rd_chk(12'h014, "R5 random pend lo");
      apb_rd_chk(12'h02C, "R5 random pend hi");
      chk_out("R8 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule